// File: doc/BRIEF.md
# Supply-Guarded Battery-Backed Byte Memory

This block is a clocked model of a nonvolatile bytewide static memory that keeps its contents on a backup cell. The host drives active-low chip select, output enable and write enable, a 15-bit address and an 8-bit write bus. All of these are sampled on the system clock. The analog side of the part is reduced to digital flags: a supply-good flag for the operating threshold, a flag for the switchover threshold, one low-voltage flag per backup battery, and a comparison flag telling which battery is stronger. The block uses them to decide whether each access is honoured and which source powers the array.

Read data comes out on a separate data bus with its own enable, one clock after the strobes are sampled. A write starts when the later of chip select and write enable goes low. It is committed when the first of the two returns high. When the supply comes back after an outage, the block records whether both batteries reported weak. If they did, it silently spoils the second memory access after power-up. Software can then detect a failed backup by writing a location and reading it back. The array depth is a parameter, and the upper address pins beyond that depth are ignored.

Top module: `bbsram_core`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `rdata_oe` is 0, `rdata` is 0 and `pwr_src` is 0 (external supply).
- R2: A clock edge that samples `vcc_ok`=1, `cs_n`=0, `oe_n`=0 and `we_n`=1 makes `rdata_oe` 1 and `rdata` equal to the stored byte at the sampled address after that edge. At every other edge both become 0.
- R3: A write interval is the run of clock edges that sample `cs_n`=0, `we_n`=0 and `vcc_ok`=1. Either strobe may fall first. The address and data sampled on the last edge of the interval are stored at the first edge that samples either strobe high, and a read on any later edge returns them.
- R4: After any edge that samples `cs_n`=0 and `we_n`=0, `rdata_oe` is 0, whatever the value of `oe_n`.
- R5: After an edge that samples `vcc_ok`=0, `rdata_oe` is 0 and no write is committed. A write interval cut short by `vcc_ok` falling is abandoned, and the stored bytes keep their values.
- R6: After an edge that samples `vcc_sw`=1, `pwr_src` is 0.
- R7: After an edge that samples `vcc_sw`=0, `pwr_src` is 1 (battery A) or 2 (battery B). `batt_low[0]` flags A and `batt_low[1]` flags B. If only A is low the result is B; if only B is low it is A; otherwise it is B when `batt_b_gt_a`=1 and A when it is 0.
- R8: An edge that samples `vcc_ok`=1, after an edge that sampled 0 (or after reset), is a power restore. It clears the access count, and it arms the inhibit exactly when both `batt_low` bits are 1 on that edge.
- R9: Completed accesses are counted from 0 after each restore. A read access completes at the first edge that samples the read condition (`cs_n`=0, `we_n`=1) no longer true; a write access completes when it commits. While the inhibit is armed, the access with index 1 is spoiled: a write stores nothing, and a read drives the bitwise complement of the stored byte. Accesses with index 0 and index 2 or higher behave normally.
- R10: Address bits at and above log2(DEPTH) are ignored, so addresses that differ only in those bits select the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of control state (the array is not cleared) |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_PINS (15) | Byte address |
| wdata | input | DATA_W (8) | Write data |
| vcc_ok | input | 1 | Supply above the operating threshold |
| vcc_sw | input | 1 | Supply above the switchover threshold |
| batt_low | input | 2 | Per-battery low-voltage flag, bit 0 battery A, bit 1 battery B |
| batt_b_gt_a | input | 1 | Battery B voltage above battery A |
| rdata | output | DATA_W (8) | Read data, 0 when not driven |
| rdata_oe | output | 1 | Read data is driven |
| pwr_src | output | 2 | Array supply source: 0 external, 1 battery A, 2 battery B |

## Verification
The hardest state to reach from the ports is the armed inhibit. Getting there takes a full outage: `vcc_ok` drops, `vcc_sw` drops, both battery flags are raised, and the supply returns while they are still raised. The count of completed accesses then has to be tracked exactly, including the read phases that the strobe orderings create implicitly around a write. The stimulus runs scripted power cycles with each battery-flag combination. After each one it performs a read, then a write or a read, then another read on one location. A behavioural model in the bench follows the access index on every clock, so a spoiled access that lands one access early or late shows up as a data mismatch.

// File: rtl/bbsram_pkg.sv
package bbsram_pkg;

   localparam int PIN_ADDR_W = 15;
   localparam int PIN_DATA_W = 8;

   typedef enum logic [1:0] {
      SRC_EXT   = 2'd0,
      SRC_BAT_A = 2'd1,
      SRC_BAT_B = 2'd2
   } pwr_src_e;

endpackage

// File: rtl/bbsram_array.sv
module bbsram_array #(
   parameter int DEPTH  = 256,
   parameter int DATA_W = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem[rd_addr];

   // R3
   commit_lands_chk: assert property (@(posedge clk)
      wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/bbsram_pwr_ctl.sv
module bbsram_pwr_ctl
   import bbsram_pkg::*;
#(
   parameter int INHIBIT_IDX = 1,
   localparam int CNT_MAX    = INHIBIT_IDX + 1,
   localparam int CNT_W      = $clog2(CNT_MAX + 1)
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     vcc_ok,
   input  logic     vcc_sw,
   input  logic [1:0] batt_low,
   input  logic     batt_b_gt_a,
   input  logic     acc_done,
   output logic     inhibit,
   output pwr_src_e pwr_src
);

   generate
      if (INHIBIT_IDX < 0) begin : g_bad_idx
         $error("INHIBIT_IDX must be non-negative");
      end
   endgenerate

   logic             vok_q;
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   pwr_src_e         src_q;
   pwr_src_e         src_nx;
   logic             restore;

   assign restore = vcc_ok && !vok_q;

   always_comb begin
      if (vcc_sw) begin
         src_nx = SRC_EXT;
      end else if (batt_low[0] && !batt_low[1]) begin
         src_nx = SRC_BAT_B;
      end else if (batt_low[1] && !batt_low[0]) begin
         src_nx = SRC_BAT_A;
      end else if (batt_b_gt_a) begin
         src_nx = SRC_BAT_B;
      end else begin
         src_nx = SRC_BAT_A;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vok_q   <= 1'b0;
         armed_q <= 1'b0;
         cnt_q   <= '0;
         src_q   <= SRC_EXT;
      end else begin
         vok_q <= vcc_ok;
         src_q <= src_nx;
         if (restore) begin
            cnt_q   <= '0;
            armed_q <= &batt_low;
         end else if (acc_done && (cnt_q != CNT_W'(CNT_MAX))) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign inhibit = armed_q && (cnt_q == CNT_W'(INHIBIT_IDX));
   assign pwr_src = src_q;

   // R6
   ext_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vcc_sw |=> (pwr_src == SRC_EXT));

   // R8
   restore_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vcc_ok) |=> (cnt_q == '0));

endmodule

// File: rtl/bbsram_bus_seq.sv
module bbsram_bus_seq #(
   parameter int AW     = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [AW-1:0]     addr_t,
   input  logic [DATA_W-1:0] wdata,
   input  logic              vcc_ok,
   input  logic              inhibit,
   input  logic [DATA_W-1:0] mem_rd,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              acc_done,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe
);

   logic              rd_ph, wr_ph, drive;
   logic              rd_ph_q, wr_ph_q;
   logic              commit, rd_done;
   logic [AW-1:0]     wa_q;
   logic [DATA_W-1:0] wd_q;
   logic [DATA_W-1:0] rdata_q;
   logic              oe_q;

   assign rd_ph   = vcc_ok && !cs_n && we_n;
   assign wr_ph   = vcc_ok && !cs_n && !we_n;
   assign drive   = rd_ph && !oe_n;
   assign commit  = wr_ph_q && !wr_ph && vcc_ok;
   assign rd_done = rd_ph_q && !rd_ph && vcc_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ph_q <= 1'b0;
         wr_ph_q <= 1'b0;
         wa_q    <= '0;
         wd_q    <= '0;
         rdata_q <= '0;
         oe_q    <= 1'b0;
      end else begin
         rd_ph_q <= rd_ph;
         wr_ph_q <= wr_ph;
         if (wr_ph) begin
            wa_q <= addr_t;
            wd_q <= wdata;
         end
         oe_q    <= drive;
         rdata_q <= drive ? (mem_rd ^ {DATA_W{inhibit}}) : '0;
      end
   end

   assign wr_en    = commit && !inhibit;
   assign wr_addr  = wa_q;
   assign wr_data  = wd_q;
   assign acc_done = commit || rd_done;
   assign rdata    = rdata_q;
   assign rdata_oe = oe_q;

endmodule

// File: rtl/bbsram_core.sv
module bbsram_core
   import bbsram_pkg::*;
#(
   parameter int DEPTH       = 256,
   parameter int ADDR_PINS   = PIN_ADDR_W,
   parameter int DATA_W      = PIN_DATA_W,
   parameter int INHIBIT_IDX = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 oe_n,
   input  logic                 we_n,
   input  logic [ADDR_PINS-1:0] addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 vcc_ok,
   input  logic                 vcc_sw,
   input  logic [1:0]           batt_low,
   input  logic                 batt_b_gt_a,
   output logic [DATA_W-1:0]    rdata,
   output logic                 rdata_oe,
   output logic [1:0]           pwr_src
);

   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_small
         $error("DEPTH must be at least 2");
      end
      if ((1 << AW) != DEPTH) begin : g_bad_pow2
         $error("DEPTH must be a power of two");
      end
      if (AW > ADDR_PINS) begin : g_bad_big
         $error("DEPTH exceeds the address pin range");
      end
   endgenerate

   logic [AW-1:0]     addr_t;
   logic [DATA_W-1:0] mem_rd;
   logic              wr_en;
   logic [AW-1:0]     wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              acc_done;
   logic              inhibit;
   pwr_src_e          src_w;

   assign addr_t = addr[AW-1:0];

   generate
      if (AW < ADDR_PINS) begin : g_trunc
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_PINS-1:AW];
      end
   endgenerate

   bbsram_array #(
      .DEPTH (DEPTH),
      .DATA_W(DATA_W)
   ) u_array (
      .clk    (clk),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(addr_t),
      .rd_data(mem_rd)
   );

   bbsram_bus_seq #(
      .AW    (AW),
      .DATA_W(DATA_W)
   ) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .oe_n    (oe_n),
      .we_n    (we_n),
      .addr_t  (addr_t),
      .wdata   (wdata),
      .vcc_ok  (vcc_ok),
      .inhibit (inhibit),
      .mem_rd  (mem_rd),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .acc_done(acc_done),
      .rdata   (rdata),
      .rdata_oe(rdata_oe)
   );

   bbsram_pwr_ctl #(
      .INHIBIT_IDX(INHIBIT_IDX)
   ) u_pwr (
      .clk        (clk),
      .rst_n      (rst_n),
      .vcc_ok     (vcc_ok),
      .vcc_sw     (vcc_sw),
      .batt_low   (batt_low),
      .batt_b_gt_a(batt_b_gt_a),
      .acc_done   (acc_done),
      .inhibit    (inhibit),
      .pwr_src    (src_w)
   );

   assign pwr_src = src_w;

   // R2
   drive_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> $past(vcc_ok && !cs_n && !oe_n && we_n));

   // R4
   write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !we_n) |=> !rdata_oe);

   // R5
   unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vcc_ok |=> !rdata_oe);

endmodule

// File: tb/bbsram_core_tb.sv
`timescale 1ns/1ps
module bbsram_core_tb_top;

   localparam int DEPTH = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [14:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        vcc_ok = 1'b1, vcc_sw = 1'b1;
   logic [1:0]  batt_low = 2'b00;
   logic        batt_b_gt_a = 1'b0;
   logic [7:0]  rdata;
   logic        rdata_oe;
   logic [1:0]  pwr_src;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   bbsram_core #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .wdata(wdata), .vcc_ok(vcc_ok), .vcc_sw(vcc_sw),
      .batt_low(batt_low), .batt_b_gt_a(batt_b_gt_a),
      .rdata(rdata), .rdata_oe(rdata_oe), .pwr_src(pwr_src)
   );

   // behavioural reference model
   int m_mem [DEPTH];
   int m_oe, m_rdata, m_src, m_cnt, m_wa, m_wd;
   bit m_arm, m_rprev, m_wprev, m_vprev;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_oe = 0; m_rdata = 0; m_src = 0; m_cnt = 0; m_arm = 0;
         m_rprev = 0; m_wprev = 0; m_vprev = 0;
      end else begin
         bit rdph, wph, inh, fin;
         int a;
         rdph = vcc_ok && !cs_n && we_n;
         wph  = vcc_ok && !cs_n && !we_n;
         inh  = m_arm && (m_cnt == 1);
         a    = int'(addr) % DEPTH;
         if (rdph && !oe_n) begin
            m_oe = 1;
            m_rdata = inh ? ((~m_mem[a]) & 255) : m_mem[a];
         end else begin
            m_oe = 0;
            m_rdata = 0;
         end
         fin = 0;
         if (m_wprev && !wph && vcc_ok) begin
            if (!inh) m_mem[m_wa] = m_wd;
            fin = 1;
         end
         if (m_rprev && !rdph && vcc_ok) fin = 1;
         if (wph) begin
            m_wa = a;
            m_wd = int'(wdata);
         end
         m_wprev = wph;
         m_rprev = rdph;
         if (vcc_ok && !m_vprev) begin
            m_cnt = 0;
            m_arm = (batt_low == 2'b11);
         end else if (fin && m_cnt < 2) begin
            m_cnt++;
         end
         m_vprev = vcc_ok;
         if (vcc_sw) m_src = 0;
         else if (batt_low[0] && !batt_low[1]) m_src = 2;
         else if (batt_low[1] && !batt_low[0]) m_src = 1;
         else m_src = batt_b_gt_a ? 2 : 1;
      end
   end

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #1;
      if (rst_n && !finished) begin
         chk(int'(rdata_oe) == m_oe, "rdata_oe", int'(rdata_oe), m_oe);
         chk(int'(rdata) == m_rdata, "rdata", int'(rdata), m_rdata);
         chk(int'(pwr_src) == m_src, "pwr_src", int'(pwr_src), m_src);
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input int a, input bit oe_low);
      @(negedge clk);
      cs_n = 0; we_n = 1; oe_n = !oe_low; addr = 15'(a);
      @(negedge clk);
      cs_n = 1; oe_n = 1;
   endtask

   // we_first: write enable falls before chip select; cs_up_first: chip select rises first
   task automatic wr(input int a, input int d, input bit we_first, input bit cs_up_first);
      @(negedge clk);
      addr = 15'(a); wdata = 8'(d);
      if (we_first) we_n = 0; else cs_n = 0;
      @(negedge clk);
      cs_n = 0; we_n = 0;
      @(negedge clk);
      if (cs_up_first) cs_n = 1; else we_n = 1;
      @(negedge clk);
      cs_n = 1; we_n = 1;
   endtask

   task automatic pwr_cycle(input logic [1:0] bl, input bit gt);
      @(negedge clk);
      vcc_ok = 0;
      idle(2);
      vcc_sw = 0; batt_low = bl; batt_b_gt_a = gt;
      idle(3);
      vcc_sw = 1;
      idle(1);
      vcc_ok = 1;
      idle(1);
   endtask

   initial begin
      idle(4);
      cur_req = "R1";
      chk(rdata_oe == 1'b0, "reset rdata_oe", int'(rdata_oe), 0);
      chk(rdata == 8'h00, "reset rdata", int'(rdata), 0);
      chk(pwr_src == 2'd0, "reset pwr_src", int'(pwr_src), 0);
      rst_n = 1;
      idle(2);

      cur_req = "R3";
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         cs_n = 0; we_n = 0; addr = 15'(i); wdata = 8'((i * 37 + 5) & 255);
         @(negedge clk);
         cs_n = 1; we_n = 1;
      end
      wr(20, 8'h11, 1, 1);
      wr(21, 8'h22, 0, 0);
      wr(22, 8'h33, 1, 0);
      wr(23, 8'h44, 0, 1);

      cur_req = "R2";
      for (int i = 18; i < 26; i++) rd(i, 1);
      rd(7, 0);
      rd(200, 1);

      cur_req = "R10";
      rd(5 + DEPTH, 1);
      rd(9 + 3 * DEPTH, 1);
      wr(30 + 2 * DEPTH, 8'h9C, 0, 1);
      rd(30, 1);

      cur_req = "R4";
      @(negedge clk);
      cs_n = 0; oe_n = 0; we_n = 1; addr = 15'd40; wdata = 8'hE7;
      idle(2);
      we_n = 0;
      idle(3);
      we_n = 1;
      idle(2);
      cs_n = 1; oe_n = 1;
      rd(40, 1);

      cur_req = "R5";
      @(negedge clk);
      vcc_ok = 0;
      rd(3, 1);
      wr(3, 8'hFF, 0, 1);
      @(negedge clk);
      vcc_ok = 1;
      rd(3, 1);
      @(negedge clk);
      cs_n = 0; we_n = 0; addr = 15'd4; wdata = 8'h00;
      @(negedge clk);
      vcc_ok = 0;
      @(negedge clk);
      cs_n = 1; we_n = 1;
      @(negedge clk);
      vcc_ok = 1;
      rd(4, 1);

      cur_req = "R6";
      pwr_cycle(2'b00, 0);
      idle(2);
      cur_req = "R7";
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         vcc_sw = 0; batt_low = 2'(k & 3); batt_b_gt_a = (k >= 4);
         idle(2);
      end
      @(negedge clk);
      vcc_sw = 1; batt_low = 2'b00;
      idle(2);

      cur_req = "R8";
      pwr_cycle(2'b11, 0);
      cur_req = "R9";
      rd(10, 1);
      wr(10, 8'hAA, 0, 1);
      rd(10, 1);
      rd(10, 1);
      cur_req = "R8";
      pwr_cycle(2'b11, 1);
      cur_req = "R9";
      rd(10, 1);
      rd(10, 1);
      wr(10, 8'h55, 1, 0);
      rd(10, 1);
      cur_req = "R8";
      pwr_cycle(2'b01, 0);
      cur_req = "R9";
      rd(12, 1);
      wr(12, 8'h3C, 0, 1);
      rd(12, 1);
      pwr_cycle(2'b11, 0);
      wr(14, 8'h01, 0, 1);
      wr(14, 8'h02, 0, 1);
      rd(14, 1);
      idle(3);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL %s watchdog actual=%0d expected=%0d", cur_req, 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule